// File: doc/BRIEF.md
# Configurable External Bus Controller

This block is the master side of an external memory bus. An internal requester asks for a read or a write by giving an address, write data, a word or byte size and a request level. The block turns each request into one or two external bus cycles. It drives a 21-bit address bus and a 16-bit address/data bus that is split into output, output-enable and input halves. It also drives an address strobe, a read strobe, a whole-word write strobe, one write strobe for each byte lane, and three active-low chip selects. It reports completion with a one-clock done pulse that carries the assembled read data.

Three address regions are each defined by a base and a mask. Each region has its own data width (8 or 16 bits), its own address/data multiplexing choice and its own wait-state count, taken from static configuration inputs. The settings of the region that the request address falls in are captured when the request is accepted, and they shape the whole access. On an 8-bit region a word is moved as two byte cycles, low byte first. An address outside every region gets no chip select and uses the settings of region 0.

Top module: `xbus_master`

## Requirements
- R1: Region k, for k = 0, 1 or 2, matches when (address & mask_k) == base_k. The default regions are address bits 20:18 equal to 0, 1 and 2. When several regions match, the lowest index wins. The region's active-low select cs_n[k] is low from the address phase through the last data clock of every bus cycle of the access. At most one select is low at any time.
- R2: An address that matches no region drives no chip select, and the access uses the width, multiplexing and wait settings of region 0.
- R3: A bus cycle is one address clock with ale high, then 1+W data clocks, where W is the region's wait count (cfg_wait bits 2k+1:2k). done is high for exactly one clock, the clock after the last data clock, and rdata is valid in that clock.
- R4: a_o carries the cycle address from the address clock through the last data clock, and it holds that value while the block is idle. Word accesses on 16-bit regions clear address bit 0.
- R5: 16-bit multiplexed (cfg_bus16=1, cfg_mux=1): both lanes drive a_o[15:0] in the address clock. In the data clocks, writes drive the data on both lanes and reads drive neither lane.
- R6: 8-bit multiplexed: the high lane drives a_o[15:8] in every clock of the cycle. The low lane drives a_o[7:0] in the address clock, then the write byte, and it is released on reads.
- R7: 8-bit demultiplexed: the high lane drives bits 15:8 of the request's write data in every clock of the cycle. The low lane is released in the address clock and drives the write byte only in write data clocks.
- R8: 16-bit demultiplexed: both lanes are released in the address clock. Only write data clocks drive them.
- R9: A word access on an 8-bit region is two back-to-back cycles, at the even address (low byte) and then at address+1 (high byte). Read data is {second byte, first byte}, and done follows only the second cycle.
- R10: In data clocks rd_n is low for reads. For writes, wrl_n is low when the low lane is written (16-bit word, 16-bit even byte, every 8-bit cycle). wrh_n is low when the high lane is written (16-bit word, 16-bit odd byte). wr_n is low for every write except 16-bit byte writes. All strobes are high in the address clock and when idle.
- R11: A byte access on a 16-bit region uses the lane picked by address bit 0. A read returns that lane zero-extended in rdata, and a write places the byte on both lanes.
- R12: A request is accepted only while idle with done low. Request inputs that change during an access, and a request still held during the done clock, have no effect on the bus.
- R13: After reset all strobes and selects are high, ale and done are low, both lanes are released and a_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one clock per state time |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request level, held until done |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 21 | Byte address of the access |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with done |
| cfg_bus16 | input | 3 | Per region: 1 = 16-bit width |
| cfg_mux | input | 3 | Per region: 1 = multiplexed address/data |
| cfg_wait | input | 6 | Per region: 2-bit wait count |
| a_o | output | 21 | Address bus |
| ad_o | output | 16 | Address/data bus, output value |
| ad_oe_lo | output | 1 | Output enable for ad_o[7:0] |
| ad_oe_hi | output | 1 | Output enable for ad_o[15:8] |
| ad_i | input | 16 | Address/data bus, input value |
| ale | output | 1 | Address latch enable, high in the address clock |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Full-width write strobe, active low |
| wrl_n | output | 1 | Low-lane write strobe, active low |
| wrh_n | output | 1 | High-lane write strobe, active low |
| cs_n | output | 3 | Region chip selects, active low |

## Verification
The assertions rely on two things about the inputs. The configuration is treated as quasi-static, so a strobe run is never longer than one plus the largest 2-bit wait count. ad_i is assumed to matter only in read data clocks, so the data lanes must never be driven while the read strobe is low. The stimulus changes the configuration only between accesses, with the block idle. Its external device model drives ad_i only while rd_n is low. The requester holds req until done and deliberately scrambles the request fields during each access to show that they are ignored.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int XB_AW = 21;
    localparam int XB_DW = 16;
    localparam int XB_WW = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } xb_phase_e;

    typedef struct packed {
        logic             bus16;
        logic             mux;
        logic [XB_WW-1:0] wt;
    } xb_cfg_t;

    // Address presented for the current bus cycle.
    function automatic logic [XB_AW-1:0] xb_cyc_addr(
        input logic [XB_AW-1:0] a,
        input logic             bus16,
        input logic             byte_acc,
        input logic             split,
        input logic             second
    );
        if (bus16)
            return byte_acc ? a : {a[XB_AW-1:1], 1'b0};
        else
            return split ? {a[XB_AW-1:1], second} : a;
    endfunction
endpackage

// File: rtl/xbus_region_dec.sv
module xbus_region_dec
    import xbus_pkg::*;
#(
    parameter int                     NCS  = 3,
    parameter int                     SW   = 2,
    parameter logic [NCS*XB_AW-1:0]   BASE = '0,
    parameter logic [NCS*XB_AW-1:0]   MASK = '0
) (
    input  logic [XB_AW-1:0] addr,
    output logic             hit,
    output logic [SW-1:0]    sel
);
    logic [NCS-1:0] match;

    for (genvar g = 0; g < NCS; g++) begin : g_cmp
        assign match[g] = ((addr & MASK[g*XB_AW +: XB_AW]) == BASE[g*XB_AW +: XB_AW]);
    end

    // Lowest index wins on overlap.
    always_comb begin
        hit = |match;
        sel = '0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (match[i]) sel = SW'(i);
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int SW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_wr,
    input  logic             req_byte,
    input  logic [XB_AW-1:0] req_addr,
    input  logic [XB_DW-1:0] req_wdata,
    input  logic             dec_hit,
    input  logic [SW-1:0]    dec_sel,
    input  xb_cfg_t          dec_cfg,
    input  logic [XB_DW-1:0] ad_i,
    output xb_phase_e        ph,
    output xb_cfg_t          cur_cfg,
    output logic             cur_hit,
    output logic [SW-1:0]    cur_sel,
    output logic             r_wr,
    output logic             r_byte,
    output logic             r_odd,
    output logic [XB_DW-1:0] r_wdata,
    output logic [XB_AW-1:0] cyc_a,
    output logic [7:0]       wbyte,
    output logic             done,
    output logic [XB_DW-1:0] rdata
);
    logic [XB_WW-1:0] wcnt;
    logic             split, second;
    logic [XB_AW-1:0] r_addr;
    logic [7:0]       lo_q;
    logic [XB_DW-1:0] asm_data;

    assign cyc_a = xb_cyc_addr(r_addr, cur_cfg.bus16, r_byte, split, second);
    assign wbyte = (split && second) ? r_wdata[15:8] : r_wdata[7:0];
    assign r_odd = r_addr[0];

    always_comb begin
        if (split)
            asm_data = {ad_i[7:0], lo_q};
        else if (r_byte)
            asm_data = {8'h00, (cur_cfg.bus16 && r_addr[0]) ? ad_i[15:8] : ad_i[7:0]};
        else
            asm_data = ad_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            wcnt    <= '0;
            split   <= 1'b0;
            second  <= 1'b0;
            cur_cfg <= '0;
            cur_hit <= 1'b0;
            cur_sel <= '0;
            r_wr    <= 1'b0;
            r_byte  <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            lo_q    <= '0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (req && !done) begin
                        ph      <= PH_ADDR;
                        cur_cfg <= dec_cfg;
                        cur_hit <= dec_hit;
                        cur_sel <= dec_sel;
                        r_wr    <= req_wr;
                        r_byte  <= req_byte;
                        r_addr  <= req_addr;
                        r_wdata <= req_wdata;
                        split   <= !req_byte && !dec_cfg.bus16;
                        second  <= 1'b0;
                    end
                end
                PH_ADDR: begin
                    ph   <= PH_DATA;
                    wcnt <= cur_cfg.wt;
                end
                PH_DATA: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - 1'b1;
                    end else if (split && !second) begin
                        second <= 1'b1;
                        lo_q   <= ad_i[7:0];
                        ph     <= PH_ADDR;
                    end else begin
                        ph    <= PH_IDLE;
                        done  <= 1'b1;
                        rdata <= asm_data;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int NCS = 3,
    parameter int SW  = 2
) (
    input  xb_phase_e        ph,
    input  xb_cfg_t          cfg,
    input  logic             cur_hit,
    input  logic [SW-1:0]    cur_sel,
    input  logic             r_wr,
    input  logic             r_byte,
    input  logic             r_odd,
    input  logic [XB_DW-1:0] r_wdata,
    input  logic [XB_AW-1:0] cyc_a,
    input  logic [7:0]       wbyte,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             wrl_n,
    output logic             wrh_n,
    output logic [NCS-1:0]   cs_n,
    output logic [XB_DW-1:0] ad_o,
    output logic             ad_oe_lo,
    output logic             ad_oe_hi
);
    logic act, in_a, in_d, wd, lane_lo, lane_hi;

    always_comb begin
        act     = (ph != PH_IDLE);
        in_a    = (ph == PH_ADDR);
        in_d    = (ph == PH_DATA);
        wd      = in_d && r_wr;
        lane_lo = !cfg.bus16 || !r_byte || !r_odd;
        lane_hi = cfg.bus16 && (!r_byte || r_odd);
        ale     = in_a;
        rd_n    = !(in_d && !r_wr);
        wrl_n   = !(wd && lane_lo);
        wrh_n   = !(wd && lane_hi);
        wr_n    = !(wd && !(cfg.bus16 && r_byte));
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(act && cur_hit && (cur_sel == SW'(g)));
    end

    always_comb begin
        ad_o     = '0;
        ad_oe_lo = 1'b0;
        ad_oe_hi = 1'b0;
        if (cfg.bus16) begin
            if (in_a && cfg.mux) begin
                ad_oe_lo = 1'b1;
                ad_oe_hi = 1'b1;
                ad_o     = cyc_a[15:0];
            end else if (wd) begin
                ad_oe_lo = 1'b1;
                ad_oe_hi = 1'b1;
                ad_o     = r_byte ? {wbyte, wbyte} : r_wdata;
            end
        end else begin
            if (act) begin
                ad_oe_hi    = 1'b1;
                ad_o[15:8]  = cfg.mux ? cyc_a[15:8] : r_wdata[15:8];
            end
            if (in_a && cfg.mux) begin
                ad_oe_lo   = 1'b1;
                ad_o[7:0]  = cyc_a[7:0];
            end else if (wd) begin
                ad_oe_lo   = 1'b1;
                ad_o[7:0]  = wbyte;
            end
        end
    end
endmodule

// File: rtl/xbus_master.sv
module xbus_master
    import xbus_pkg::*;
#(
    parameter int                   NCS     = 3,
    parameter logic [NCS*XB_AW-1:0] CS_BASE = {21'h080000, 21'h040000, 21'h000000},
    parameter logic [NCS*XB_AW-1:0] CS_MASK = {21'h1C0000, 21'h1C0000, 21'h1C0000}
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic                   req_wr,
    input  logic                   req_byte,
    input  logic [XB_AW-1:0]       req_addr,
    input  logic [XB_DW-1:0]       req_wdata,
    output logic                   done,
    output logic [XB_DW-1:0]       rdata,
    input  logic [NCS-1:0]         cfg_bus16,
    input  logic [NCS-1:0]         cfg_mux,
    input  logic [NCS*XB_WW-1:0]   cfg_wait,
    output logic [XB_AW-1:0]       a_o,
    output logic [XB_DW-1:0]       ad_o,
    output logic                   ad_oe_lo,
    output logic                   ad_oe_hi,
    input  logic [XB_DW-1:0]       ad_i,
    output logic                   ale,
    output logic                   rd_n,
    output logic                   wr_n,
    output logic                   wrl_n,
    output logic                   wrh_n,
    output logic [NCS-1:0]         cs_n
);
    localparam int SW = (NCS > 1) ? $clog2(NCS) : 1;

    logic             dec_hit;
    logic [SW-1:0]    dec_sel, pick;
    xb_cfg_t          dec_cfg, cur_cfg;
    xb_phase_e        ph;
    logic             cur_hit, r_wr, r_byte, r_odd;
    logic [SW-1:0]    cur_sel;
    logic [XB_DW-1:0] r_wdata;
    logic [XB_AW-1:0] cyc_a;
    logic [7:0]       wbyte;

    xbus_region_dec #(.NCS(NCS), .SW(SW), .BASE(CS_BASE), .MASK(CS_MASK)) u_dec (
        .addr (req_addr),
        .hit  (dec_hit),
        .sel  (dec_sel)
    );

    // Unmatched addresses borrow region 0's settings.
    always_comb begin
        pick          = dec_hit ? dec_sel : '0;
        dec_cfg.bus16 = cfg_bus16[pick];
        dec_cfg.mux   = cfg_mux[pick];
        dec_cfg.wt    = cfg_wait[pick*XB_WW +: XB_WW];
    end

    xbus_seq #(.SW(SW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_wr    (req_wr),
        .req_byte  (req_byte),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dec_hit   (dec_hit),
        .dec_sel   (dec_sel),
        .dec_cfg   (dec_cfg),
        .ad_i      (ad_i),
        .ph        (ph),
        .cur_cfg   (cur_cfg),
        .cur_hit   (cur_hit),
        .cur_sel   (cur_sel),
        .r_wr      (r_wr),
        .r_byte    (r_byte),
        .r_odd     (r_odd),
        .r_wdata   (r_wdata),
        .cyc_a     (cyc_a),
        .wbyte     (wbyte),
        .done      (done),
        .rdata     (rdata)
    );

    assign a_o = cyc_a;

    xbus_drive #(.NCS(NCS), .SW(SW)) u_drv (
        .ph       (ph),
        .cfg      (cur_cfg),
        .cur_hit  (cur_hit),
        .cur_sel  (cur_sel),
        .r_wr     (r_wr),
        .r_byte   (r_byte),
        .r_odd    (r_odd),
        .r_wdata  (r_wdata),
        .cyc_a    (cyc_a),
        .wbyte    (wbyte),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wrl_n    (wrl_n),
        .wrh_n    (wrh_n),
        .cs_n     (cs_n),
        .ad_o     (ad_o),
        .ad_oe_lo (ad_oe_lo),
        .ad_oe_hi (ad_oe_hi)
    );
endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk
    import xbus_pkg::*;
#(
    parameter int NCS = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             wrl_n,
    input logic             wrh_n,
    input logic [NCS-1:0]   cs_n,
    input logic [XB_AW-1:0] a_o,
    input logic             ad_oe_lo,
    input logic             done
);
    localparam int MAXRUN = 1 + (2 ** XB_WW - 1);

    logic strobe_any;
    int   run;

    assign strobe_any = !rd_n || !wr_n || !wrl_n || !wrh_n;

    always_ff @(posedge clk) begin
        if (rst)             run <= 0;
        else if (strobe_any) run <= run + 1;
        else                 run <= 0;
    end

    a_r1_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    a_r3_ale_one_clock: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    a_r3_done_one_clock: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_strobe_after_ale: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_any) |-> $past(ale));

    a_r3_strobe_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run <= MAXRUN);

    a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
        ale |=> $stable(a_o));

    a_r10_no_strobe_with_ale: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n && wrl_n && wrh_n));

    a_r10_read_write_excl: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (wr_n && wrl_n && wrh_n));

    a_r5_read_lane_released: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe_lo);
endmodule

bind xbus_master xbus_master_chk #(.NCS(NCS)) u_xbus_chk (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .wrl_n    (wrl_n),
    .wrh_n    (wrh_n),
    .cs_n     (cs_n),
    .a_o      (a_o),
    .ad_oe_lo (ad_oe_lo),
    .done     (done)
);

// File: tb/xbus_master_bench.sv
`timescale 1ns/1ps
module xbus_master_bench;
    // Tags: R1 select, R2 unmatched, R3 timing, R4 address, R5 mux16,
    // R6 mux8, R7 demux8, R8 demux16, R9 split, R10 strobes,
    // R11 16-bit byte, R12 ignored request, R13 reset.
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_wr = 1'b0, req_byte = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic [2:0]  t_b16 = '0, t_mux = '0;
    logic [5:0]  t_wait = '0;
    logic [20:0] a_o;
    logic [15:0] ad_o, ad_i;
    logic        ad_oe_lo, ad_oe_hi, ale, rd_n, wr_n, wrl_n, wrh_n;
    logic [2:0]  cs_n;
    logic        cur_b16 = 1'b1;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    xbus_master u_xbus_master (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_byte(req_byte),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .cfg_bus16(t_b16), .cfg_mux(t_mux), .cfg_wait(t_wait),
        .a_o(a_o), .ad_o(ad_o), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi),
        .ad_i(ad_i), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .wrl_n(wrl_n),
        .wrh_n(wrh_n), .cs_n(cs_n)
    );

    function automatic logic [7:0] devb(input logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
    endfunction

    // External device: answers only while the read strobe is low.
    always_comb begin
        if (rd_n) ad_i = 16'h0000;
        else ad_i = {devb(a_o | 21'h1), cur_b16 ? devb(a_o & ~21'h1) : devb(a_o)};
    end

    typedef struct {
        logic        ale, rd_n, wr_n, wrl_n, wrh_n, done, chk_rd;
        logic [2:0]  cs_n;
        logic [20:0] a;
        logic        oe_lo, oe_hi;
        logic [7:0]  lo, hi;
        logic [15:0] rdata;
        int          stag, cstag, ltag, rtag;
    } exp_t;

    exp_t q[$];

    function automatic exp_t idle_exp(input logic [20:0] a);
        exp_t e;
        e.ale = 0; e.rd_n = 1; e.wr_n = 1; e.wrl_n = 1; e.wrh_n = 1;
        e.done = 0; e.chk_rd = 0; e.cs_n = 3'b111; e.a = a;
        e.oe_lo = 0; e.oe_hi = 0; e.lo = 0; e.hi = 0; e.rdata = 0;
        e.stag = 10; e.cstag = 1; e.ltag = 3; e.rtag = 3;
        return e;
    endfunction

    task automatic chk(input string what, input int tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input exp_t e);
        chk("ale", (e.stag == 10) ? 3 : e.stag, 32'(ale), 32'(e.ale));
        chk("done", (e.stag == 10) ? 3 : e.stag, 32'(done), 32'(e.done));
        chk("rd_n", e.stag, 32'(rd_n), 32'(e.rd_n));
        chk("wr_n", e.stag, 32'(wr_n), 32'(e.wr_n));
        chk("wrl_n", e.stag, 32'(wrl_n), 32'(e.wrl_n));
        chk("wrh_n", e.stag, 32'(wrh_n), 32'(e.wrh_n));
        chk("cs_n", e.cstag, 32'(cs_n), 32'(e.cs_n));
        chk("a_o", (e.stag == 12 || e.stag == 13) ? e.stag : 4, 32'(a_o), 32'(e.a));
        chk("oe_lo", e.ltag, 32'(ad_oe_lo), 32'(e.oe_lo));
        chk("oe_hi", e.ltag, 32'(ad_oe_hi), 32'(e.oe_hi));
        if (e.oe_lo) chk("ad_lo", e.ltag, 32'(ad_o[7:0]), 32'(e.lo));
        if (e.oe_hi) chk("ad_hi", e.ltag, 32'(ad_o[15:8]), 32'(e.hi));
        if (e.chk_rd) chk("rdata", e.rtag, 32'(rdata), 32'(e.rdata));
    endtask

    task automatic run_txn(input logic wr, input logic byt, input logic [20:0] addr, input logic [15:0] wd);
        logic        hitk, b16, mx;
        int          k, wt, n, mtag;
        logic [20:0] ca, ae;
        logic [7:0]  bd;
        logic [2:0]  csx;
        exp_t        e;
        bit          first;
        hitk = (addr[20:18] < 3'd3);
        k    = hitk ? int'(addr[20:18]) : 0;
        b16  = t_b16[k];
        mx   = t_mux[k];
        wt   = int'(t_wait[k*2 +: 2]);
        csx  = hitk ? ~(3'b001 << k) : 3'b111;
        mtag = b16 ? (mx ? 5 : 8) : (mx ? 6 : 7);
        if (b16 && byt) mtag = 11;
        n    = (!b16 && !byt) ? 2 : 1;
        ae   = {addr[20:1], 1'b0};
        ca   = addr;
        for (int s = 0; s < n; s++) begin
            if (b16) ca = byt ? addr : ae;
            else     ca = (n == 2) ? (ae | 21'(s)) : addr;
            bd = (n == 2 && s == 1) ? wd[15:8] : wd[7:0];
            e = idle_exp(ca); e.ale = 1; e.cs_n = csx; e.stag = 3;
            e.cstag = hitk ? 1 : 2; e.ltag = mtag;
            if (mx) begin e.oe_lo = 1; e.oe_hi = 1; e.lo = ca[7:0]; e.hi = ca[15:8]; end
            else if (!b16) begin e.oe_hi = 1; e.hi = wd[15:8]; end
            q.push_back(e);
            for (int d = 0; d <= wt; d++) begin
                e = idle_exp(ca); e.cs_n = csx; e.cstag = hitk ? 1 : 2; e.ltag = mtag;
                if (!wr) e.rd_n = 0;
                else begin
                    e.wr_n  = (b16 && byt) ? 1'b1 : 1'b0;
                    e.wrl_n = !(!b16 || !byt || !addr[0]);
                    e.wrh_n = !(b16 && (!byt || addr[0]));
                end
                if (b16) begin
                    if (wr) begin
                        e.oe_lo = 1; e.oe_hi = 1;
                        e.lo = byt ? bd : wd[7:0];
                        e.hi = byt ? bd : wd[15:8];
                    end
                end else begin
                    e.oe_hi = 1; e.hi = mx ? ca[15:8] : wd[15:8];
                    if (wr) begin e.oe_lo = 1; e.lo = bd; end
                end
                q.push_back(e);
            end
        end
        e = idle_exp(ca); e.done = 1; e.stag = 3; e.chk_rd = !wr;
        e.rdata = byt ? {8'h00, devb(addr)} : {devb(ae | 21'h1), devb(ae)};
        e.rtag = (n == 2) ? 9 : (byt ? 11 : 3);
        q.push_back(e);
        e = idle_exp(ca); e.stag = 12; e.cstag = 12; e.ltag = 12;
        q.push_back(e);
        cur_b16   = b16;
        req_wr    = wr;
        req_byte  = byt;
        req_addr  = addr;
        req_wdata = wd;
        req       = 1'b1;
        first     = 1;
        while (q.size() > 0) begin
            @(posedge clk);
            @(negedge clk);
            e = q.pop_front();
            compare(e);
            if (first) begin
                // R12: fields changed mid-access must not matter.
                req_addr  = ~addr;
                req_wdata = ~wd;
                req_wr    = !wr;
                req_byte  = !byt;
                first     = 0;
            end
        end
        req = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!finished) begin
                    errors++;
                    $display("FAIL R3 watchdog actual=hung expected=finished");
                    $display("  CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        begin
            exp_t e;
            e = idle_exp(21'h0); e.stag = 13; e.cstag = 13; e.ltag = 13;
            compare(e); // R13 reset state
        end

        // Set A: region0 16-bit demux W0, region1 8-bit mux W1, region2 16-bit mux W2
        t_b16 = 3'b101; t_mux = 3'b110; t_wait = {2'd2, 2'd1, 2'd0};
        run_txn(0, 0, 21'h001234, 16'h0000);  // R8 R3 word read
        run_txn(1, 0, 21'h002468, 16'hA1B2);  // R8 R10 word write
        run_txn(1, 1, 21'h000011, 16'h00C3);  // R11 odd byte write
        run_txn(1, 1, 21'h000010, 16'h00D4);  // R11 even byte write
        run_txn(0, 1, 21'h000777, 16'h0000);  // R11 odd byte read
        run_txn(0, 0, 21'h040100, 16'h0000);  // R9 R6 split read
        run_txn(1, 0, 21'h041235, 16'h5E6F);  // R9 R6 split write, odd addr
        run_txn(0, 1, 21'h040101, 16'h0000);  // R6 byte read
        run_txn(0, 0, 21'h080222, 16'h0000);  // R5 word read W2
        run_txn(1, 1, 21'h080223, 16'h0077);  // R5 R11 byte write
        run_txn(0, 0, 21'h150000, 16'h0000);  // R2 unmatched, region0 settings

        // Set B: region0 8-bit demux W3, region1 16-bit mux W0, region2 8-bit demux W0
        t_b16 = 3'b010; t_mux = 3'b010; t_wait = {2'd0, 2'd0, 2'd3};
        run_txn(1, 0, 21'h1A0003, 16'h9C8D);  // R2 R7 R9 unmatched split write
        run_txn(0, 0, 21'h000ABC, 16'h3344);  // R7 R9 split read W3
        run_txn(1, 1, 21'h000ABD, 16'hEE21);  // R7 byte write
        run_txn(1, 0, 21'h04FFFE, 16'h1357);  // R5 word write W0
        run_txn(0, 1, 21'h0A0005, 16'h8800);  // R7 byte read region2
        run_txn(0, 0, 21'h000ABC, 16'h0000);  // R1 back-to-back

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule